// File: doc/BRIEF.md
# NAND Page Buffer with Lazy Erase

This block is the page-sized staging store that sits between a serial NAND front end and its array. It holds 2112 bytes, addressed by a 12-bit column: columns 0 to 2047 carry page data and columns 2048 to 2111 carry the spare area. Byte-wide push and pop ports replace the serial lanes. A host can load it from a chosen column in two ways: one that first makes every byte read as 0xFF and one that keeps whatever was there. The array side fills it from column 0. A streaming read pops bytes back out.

The read range follows a mode input. In buffer mode a read starts at the given column and runs through the spare area. In continuous mode a read always starts at column 0 and covers only the 2048 data bytes. It then raises a one-cycle page-done pulse, stalls, and resumes at column 0 once the array has refilled the buffer. The 0xFF reset costs a single cycle because each byte carries a valid flag, and a byte whose flag is clear reads as 0xFF.

Top module: `nand_page_buf`

## Requirements
- R1: After reset, every column reads 0xFF, `rd_valid` is 0 and `page_done` is 0.
- R2: A normal load (`load_start` with `load_random`=0) writes pushed bytes at consecutive columns from `load_col`. Every other column then reads 0xFF.
- R3: A random load (`load_random`=1) writes pushed bytes the same way and leaves every other column unchanged.
- R4: Pushed or filled bytes aimed at columns above 2111 are discarded, including a load whose start column is above 2111.
- R5: An array fill (`fill_start`, then `fill_valid` bytes, then `fill_done`) writes bytes at consecutive columns from column 0.
- R6: A buffer-mode read (`buf_mode`=1) presents the byte at `read_col` with `rd_valid`=1 and advances one column per cycle with `rd_ready`=1. It reaches the spare area and returns 0xFF past column 2111. While `rd_ready`=0 and no command arrives, the data holds.
- R7: A continuous-mode read (`buf_mode`=0) ignores `read_col` and streams columns 0 to 2047. The cycle after column 2047 is popped, `page_done` is 1 for exactly one cycle and `rd_valid` drops. Streaming restarts at column 0 in the cycle after `fill_done` ends a refill.
- R8: `op_end` returns the block to idle in the next cycle. It has priority over every other command.
- R9: `wr_valid` and `fill_valid` have no effect while no matching load or fill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_mode | input | 1 | Read range: 1 = buffer mode, 0 = continuous mode (sampled at `read_start`) |
| load_start | input | 1 | Begin a host load at `load_col` |
| load_random | input | 1 | 1 = keep other bytes, 0 = all other bytes read 0xFF |
| load_col | input | 12 | Start column of a host load |
| wr_valid | input | 1 | Push strobe for host data |
| wr_data | input | 8 | Host data byte |
| fill_start | input | 1 | Begin an array fill at column 0 |
| fill_valid | input | 1 | Push strobe for array data |
| fill_data | input | 8 | Array data byte |
| fill_done | input | 1 | End of array fill |
| read_start | input | 1 | Begin a streaming read |
| read_col | input | 12 | Start column in buffer mode |
| rd_ready | input | 1 | Pop strobe |
| op_end | input | 1 | Abort or finish the current operation |
| rd_valid | output | 1 | A read byte is presented |
| rd_data | output | 8 | Presented read byte |
| page_done | output | 1 | One-cycle request for the next array page |

## Verification
A corrupted valid flag shows as a wrong byte on `rd_data`: a stale value where 0xFF is due, or 0xFF where data is due. It appears in the same cycle the read pointer lands on that column. A pointer fault, such as a wrong start column, a bad increment or no stop at the end, shows as a shifted stream at the first or last popped byte. A state fault in continuous mode shows within one cycle as a missing or doubled `page_done`, or a `rd_valid` that stays high after column 2047.

// File: rtl/npb_pkg.sv
package npb_pkg;
    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_LOAD = 3'd1,
        OP_FILL = 3'd2,
        OP_READ = 3'd3,
        OP_WAIT = 3'd4
    } op_e;
endpackage

// File: rtl/npb_store.sv
module npb_store #(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int COL_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             we,
    input  logic [COL_W:0]   waddr,
    input  logic [7:0]       wdata,
    input  logic [COL_W:0]   raddr,
    output logic [7:0]       rdata
);
    localparam int TOTAL = DATA_BYTES + SPARE_BYTES;
    localparam int AW    = COL_W + 1;
    localparam int IW    = $clog2(TOTAL);
    localparam logic [AW-1:0] TOTAL_A = AW'(TOTAL);

    logic [7:0]       mem [TOTAL];
    logic [TOTAL-1:0] vld;
    logic             w_in;
    logic             r_in;

    assign w_in = we && (waddr < TOTAL_A);
    assign r_in = raddr < TOTAL_A;

    always_ff @(posedge clk) begin
        if (w_in) begin
            mem[waddr[IW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (clr_all) begin
                vld <= '0;
            end
            if (w_in) begin
                vld[waddr[IW-1:0]] <= 1'b1;
            end
        end
    end

    assign rdata = (r_in && vld[raddr[IW-1:0]]) ? mem[raddr[IW-1:0]] : 8'hFF;
endmodule

// File: rtl/npb_ctrl.sv
module npb_ctrl
    import npb_pkg::*;
#(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int COL_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_mode,
    input  logic             load_start,
    input  logic             load_random,
    input  logic [COL_W-1:0] load_col,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             fill_start,
    input  logic             fill_valid,
    input  logic [7:0]       fill_data,
    input  logic             fill_done,
    input  logic             read_start,
    input  logic [COL_W-1:0] read_col,
    input  logic             rd_ready,
    input  logic             op_end,
    output logic             clr_all,
    output logic             we,
    output logic [COL_W:0]   waddr,
    output logic [7:0]       wdata,
    output logic [COL_W:0]   raddr,
    output logic             rd_valid,
    output logic             page_done
);
    localparam int AW = COL_W + 1;
    localparam logic [AW-1:0] TOTAL_A   = AW'(DATA_BYTES + SPARE_BYTES);
    localparam logic [AW-1:0] LAST_DATA = AW'(DATA_BYTES - 1);

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] ptr;
        logic          cont;
        logic          resume;
        logic          done;
    } state_t;

    state_t q, d;
    logic   ptr_room;

    assign ptr_room = q.ptr < TOTAL_A;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        clr_all = 1'b0;
        we      = 1'b0;
        wdata   = wr_data;
        if (op_end) begin
            d.op     = OP_IDLE;
            d.resume = 1'b0;
        end else if (load_start) begin
            d.op    = OP_LOAD;
            d.ptr   = {1'b0, load_col};
            clr_all = !load_random;
        end else if (fill_start) begin
            d.resume = (q.op == OP_WAIT);
            d.op     = OP_FILL;
            d.ptr    = '0;
        end else if (fill_done && q.op == OP_FILL) begin
            d.op     = q.resume ? OP_READ : OP_IDLE;
            d.ptr    = '0;
            d.resume = 1'b0;
        end else if (read_start) begin
            d.op   = OP_READ;
            d.cont = !buf_mode;
            d.ptr  = buf_mode ? {1'b0, read_col} : '0;
        end else begin
            unique case (q.op)
                OP_LOAD: begin
                    if (wr_valid) begin
                        we = 1'b1;
                        if (ptr_room) d.ptr = q.ptr + AW'(1);
                    end
                end
                OP_FILL: begin
                    wdata = fill_data;
                    if (fill_valid) begin
                        we = 1'b1;
                        if (ptr_room) d.ptr = q.ptr + AW'(1);
                    end
                end
                OP_READ: begin
                    if (rd_ready) begin
                        if (q.cont && q.ptr == LAST_DATA) begin
                            d.op   = OP_WAIT;
                            d.done = 1'b1;
                        end else if (ptr_room) begin
                            d.ptr = q.ptr + AW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{op: OP_IDLE, ptr: '0, cont: 1'b0, resume: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign waddr     = q.ptr;
    assign raddr     = q.ptr;
    assign rd_valid  = (q.op == OP_READ);
    assign page_done = q.done;
endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int COL_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_mode,
    input  logic             load_start,
    input  logic             load_random,
    input  logic [COL_W-1:0] load_col,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             fill_start,
    input  logic             fill_valid,
    input  logic [7:0]       fill_data,
    input  logic             fill_done,
    input  logic             read_start,
    input  logic [COL_W-1:0] read_col,
    input  logic             rd_ready,
    input  logic             op_end,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             page_done
);
    logic             clr_all;
    logic             we;
    logic [COL_W:0]   waddr;
    logic [7:0]       wdata;
    logic [COL_W:0]   raddr;

    npb_ctrl #(
        .DATA_BYTES (DATA_BYTES),
        .SPARE_BYTES(SPARE_BYTES),
        .COL_W      (COL_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_mode   (buf_mode),
        .load_start (load_start),
        .load_random(load_random),
        .load_col   (load_col),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .fill_start (fill_start),
        .fill_valid (fill_valid),
        .fill_data  (fill_data),
        .fill_done  (fill_done),
        .read_start (read_start),
        .read_col   (read_col),
        .rd_ready   (rd_ready),
        .op_end     (op_end),
        .clr_all    (clr_all),
        .we         (we),
        .waddr      (waddr),
        .wdata      (wdata),
        .raddr      (raddr),
        .rd_valid   (rd_valid),
        .page_done  (page_done)
    );

    npb_store #(
        .DATA_BYTES (DATA_BYTES),
        .SPARE_BYTES(SPARE_BYTES),
        .COL_W      (COL_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_all(clr_all),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .raddr  (raddr),
        .rdata  (rd_data)
    );
endmodule

// File: rtl/npb_checker.sv
module npb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       load_start,
    input logic       fill_start,
    input logic       fill_done,
    input logic       read_start,
    input logic       rd_ready,
    input logic       op_end,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       page_done
);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> !page_done);

    a_r7_done_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |-> !rd_valid);

    a_r7_done_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |-> $past(rd_valid && rd_ready));

    a_r8_end_idles: assert property (@(posedge clk) disable iff (!rst_n)
        op_end |=> !rd_valid);

    a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !load_start && !fill_start && !fill_done
         && !read_start && !op_end) |=> (rd_valid && $stable(rd_data)));
endmodule

bind nand_page_buf npb_checker u_npb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_start(load_start),
    .fill_start(fill_start),
    .fill_done (fill_done),
    .read_start(read_start),
    .rd_ready  (rd_ready),
    .op_end    (op_end),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .page_done (page_done)
);

// File: tb/nand_page_buf_bench.sv
`timescale 1ns/1ps
module nand_page_buf_bench;
    localparam int TOTAL = 2112;
    localparam int DATA  = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_mode = 1'b1;
    logic        load_start = 1'b0;
    logic        load_random = 1'b0;
    logic [11:0] load_col = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        fill_start = 1'b0;
    logic        fill_valid = 1'b0;
    logic [7:0]  fill_data = '0;
    logic        fill_done = 1'b0;
    logic        read_start = 1'b0;
    logic [11:0] read_col = '0;
    logic        rd_ready = 1'b0;
    logic        op_end = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        page_done;

    logic [7:0]  refm [TOTAL];
    int          n_chk = 0;
    int          n_fail = 0;
    int unsigned seed_val;

    always #2.5 clk = ~clk;

    nand_page_buf u_nand_page_buf (
        .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode),
        .load_start(load_start), .load_random(load_random), .load_col(load_col),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .fill_start(fill_start), .fill_valid(fill_valid), .fill_data(fill_data),
        .fill_done(fill_done), .read_start(read_start), .read_col(read_col),
        .rd_ready(rd_ready), .op_end(op_end),
        .rd_valid(rd_valid), .rd_data(rd_data), .page_done(page_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] expb(input int a);
        return (a < TOTAL) ? refm[a] : 8'hFF;
    endfunction

    task automatic do_load(input int col, input int n, input bit rnd);
        @(negedge clk);
        load_start = 1'b1; load_random = rnd; load_col = 12'(col);
        if (!rnd) for (int k = 0; k < TOTAL; k++) refm[k] = 8'hFF;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            load_start = 1'b0; wr_valid = 1'b1; wr_data = 8'($urandom);
            if (col + i < TOTAL) refm[col + i] = wr_data;
        end
        @(negedge clk);
        load_start = 1'b0; wr_valid = 1'b0; op_end = 1'b1;
        @(negedge clk);
        op_end = 1'b0;
    endtask

    task automatic do_fill(input int n);
        @(negedge clk);
        fill_start = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fill_start = 1'b0; fill_valid = 1'b1; fill_data = 8'($urandom);
            if (i < TOTAL) refm[i] = fill_data;
        end
        @(negedge clk);
        fill_start = 1'b0; fill_valid = 1'b0; fill_done = 1'b1;
        @(negedge clk);
        fill_done = 1'b0;
    endtask

    task automatic read_check(input int col, input int n, input string tag);
        @(negedge clk);
        buf_mode = 1'b1; read_col = 12'(col); read_start = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            read_start = 1'b0; rd_ready = 1'b1;
            chk(rd_valid == 1'b1, {tag, " valid"}, rd_valid, 1);
            chk(rd_data == expb(col + i), tag, rd_data, expb(col + i));
        end
        @(negedge clk);
        rd_ready = 1'b0; op_end = 1'b1;
        @(negedge clk);
        op_end = 1'b0;
        chk(rd_valid == 1'b0, "R8 idle after op_end", rd_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'd2024);
        for (int k = 0; k < TOTAL; k++) refm[k] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(page_done == 1'b0, "R1 page_done", page_done, 0);
        read_check(0, TOTAL + 2, "R1 erased");

        do_load(10, 5, 1'b0);
        read_check(0, 30, "R2 normal load");
        do_load(20, 5, 1'b1);
        read_check(0, 30, "R3 random load");

        do_load(2100, 20, 1'b1);
        read_check(2090, 30, "R4 clip at end");
        do_load(3000, 5, 1'b1);
        read_check(2105, 10, "R4 start beyond end");

        // R9: strobes in idle leave contents alone
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'h5A; fill_valid = 1'b1; fill_data = 8'hA5;
        repeat (3) @(negedge clk);
        wr_valid = 1'b0; fill_valid = 1'b0;
        read_check(8, 20, "R9 idle strobes");

        do_fill(TOTAL);
        read_check(0, TOTAL, "R5 R6 full fill and spare");
        do_load(50, 3, 1'b0);
        read_check(40, 20, "R2 load after fill");

        // R6: data holds while not popped
        do_fill(TOTAL);
        @(negedge clk);
        buf_mode = 1'b1; read_col = 12'd2040; read_start = 1'b1;
        @(negedge clk);
        read_start = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(rd_data == refm[2040], "R6 hold", rd_data, refm[2040]);
        end
        @(negedge clk);
        op_end = 1'b1;
        @(negedge clk);
        op_end = 1'b0;

        // R7: continuous mode
        @(negedge clk);
        buf_mode = 1'b0; read_col = 12'd100; read_start = 1'b1;
        for (int i = 0; i < DATA; i++) begin
            @(negedge clk);
            read_start = 1'b0; rd_ready = 1'b1;
            chk(rd_valid && rd_data == refm[i], "R7 stream", rd_data, refm[i]);
        end
        @(negedge clk);
        chk(page_done == 1'b1, "R7 page_done high", page_done, 1);
        chk(rd_valid == 1'b0, "R7 stall", rd_valid, 0);
        @(negedge clk);
        chk(page_done == 1'b0, "R7 page_done pulse", page_done, 0);
        chk(rd_valid == 1'b0, "R7 still stalled", rd_valid, 0);
        rd_ready = 1'b0;
        do_fill(TOTAL);
        for (int i = 0; i < 4; i++) begin
            chk(rd_valid && rd_data == refm[i], "R7 resume", rd_data, refm[i]);
            rd_ready = 1'b1;
            @(negedge clk);
        end
        rd_ready = 1'b0; op_end = 1'b1;
        @(negedge clk);
        op_end = 1'b0; buf_mode = 1'b1;
        chk(rd_valid == 1'b0, "R8 end of continuous", rd_valid, 0);

        for (int it = 0; it < 8; it++) begin
            int c;
            int n;
            c = int'($urandom_range(0, TOTAL - 1));
            n = int'($urandom_range(1, 40));
            do_load(c, n, 1'($urandom));
            read_check((c > 10) ? c - 10 : 0, 60, "R2 R3 random mix");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule